// File: doc/BRIEF.md
# Opcode Page Escape Stack

This block keeps track of which alternative opcode page the compressed-instruction decoder should use. A page-select instruction pushes an entry holding a 3-bit sub-page number and a 4-bit activation length. The top entry of a four-deep stack picks the active page. Each retired instruction counts down the top entry's length, and the entry leaves the stack by itself when its count runs out. The length code 15 means the page stays active until it is removed explicitly.

Software can drop one entry or return to the base instruction set at once. A taken branch does the same as the return to the base set. The whole state is visible as a single packed CSR word and can be written back through a CSR port, so a caller can save and restore it around a function call. Decoding of the instructions themselves happens elsewhere. The block only reports the active page and whether the base instruction set is in force.

Top module: `opage_esc_stack`

## Requirements
- R1: After a synchronous reset the stack is empty: `default_mode`=1, `active_page`=0, `csr_rdata`=0 and `overflow`=0.
- R2: A push with a nonzero length at depth below 4 writes {page, length} into entry index = old depth and raises the depth by one. In `csr_rdata`, entry i takes bits [7i+6:7i+4] for the page and [7i+3:7i] for the length, and the depth sits in bits [30:28].
- R3: A push at depth 4 leaves the state unchanged and sets `overflow` for exactly the following cycle. A push with length 0 leaves the state unchanged and does not set `overflow`.
- R4: On a retire, a top entry with a length from 2 to 14 is decremented by one. A top entry with a length of 1 or 0 is removed, which clears its bits and lowers the depth by one.
- R5: On a retire, a top entry with length 15 is left unchanged.
- R6: A taken branch empties the stack and clears all entry bits. It overrides a retire, push or pop in the same cycle.
- R7: A reset-to-default command empties the stack and clears all entry bits.
- R8: A pop removes only the top entry and clears its bits. The entries below it are untouched. At depth 0 a pop changes nothing.
- R9: A CSR write loads all entries and the depth from `csr_wdata` and overrides every other input in the same cycle. A depth field above 4 is loaded as 4. Entries at an index equal to or above the loaded depth are stored as zero.
- R10: When more than one of pop, push and retire arrive together, the pop is applied first, then the push, then the retire, and only one of them takes effect. A cycle in which a push or pop takes effect does not count down the top entry.
- R11: When the depth is above 0, `active_page` equals the top entry's page and `default_mode`=0. At depth 0, `active_page`=0 and `default_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push a new sub-page entry |
| push_page | input | 3 | Sub-page number to push |
| push_len | input | 4 | Activation length to push (15 = permanent) |
| pop_one | input | 1 | Remove the top entry |
| go_default | input | 1 | Empty the stack and return to the base instruction set |
| retire | input | 1 | One instruction retired |
| branch_taken | input | 1 | A branch was taken |
| csr_we | input | 1 | Load the packed state from `csr_wdata` |
| csr_wdata | input | 31 | Packed state to load |
| active_page | output | 3 | Page selected by the top entry |
| default_mode | output | 1 | High when the stack is empty |
| csr_rdata | output | 31 | Packed current state |
| overflow | output | 1 | One-cycle flag after a push into a full stack |

## Verification
The bench builds the block with its default sizes: four entries of 3-bit pages and 4-bit lengths, packed with a 3-bit depth into a 31-bit word. With only four entries, random pushes fill the stack often, so overflow attempts and expiries at every depth occur many times. With 4-bit lengths, countdowns to zero complete within a few retires, so the automatic removal of entries is exercised many times. Because the depth field is 3 bits wide, CSR writes with random data regularly carry the depth values 5 to 7 and so exercise the clamping.

// File: rtl/opage_pkg.sv
`timescale 1ns/1ps
package opage_pkg;
  parameter int PAGE_W  = 3;
  parameter int LEN_W   = 4;
  parameter int STACK_N = 4;
  localparam int ENTRY_W = PAGE_W + LEN_W;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [LEN_W-1:0]  len;
  } entry_t;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_CLEAR,
    OP_PUSH,
    OP_FULL,
    OP_POP,
    OP_DEC,
    OP_EXPIRE
  } op_e;
endpackage

// File: rtl/opage_cmd.sv
`timescale 1ns/1ps
module opage_cmd
  import opage_pkg::*;
#(
  parameter int STACK_N = opage_pkg::STACK_N,
  localparam int DEPTH_W = $clog2(STACK_N + 1)
) (
  input  logic               csr_we,
  input  logic               branch_taken,
  input  logic               go_default,
  input  logic               pop_one,
  input  logic               push_valid,
  input  logic [LEN_W-1:0]   push_len,
  input  logic               retire,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [LEN_W-1:0]   top_len,
  output op_e                op
);
  localparam logic [LEN_W-1:0]   PERM = '1;
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STACK_N);

  // One operation per cycle: CSR load, then clears, then pop, push, retire.
  always_comb begin
    op = OP_HOLD;
    if (csr_we) begin
      op = OP_LOAD;
    end else if (branch_taken || go_default) begin
      op = OP_CLEAR;
    end else if (pop_one) begin
      if (depth != '0) op = OP_POP;
    end else if (push_valid) begin
      if (push_len == '0)   op = OP_HOLD;
      else if (depth == FULL) op = OP_FULL;
      else                  op = OP_PUSH;
    end else if (retire && (depth != '0)) begin
      if (top_len == PERM)               op = OP_HOLD;
      else if (top_len <= LEN_W'(1))     op = OP_EXPIRE;
      else                               op = OP_DEC;
    end
  end
endmodule

// File: rtl/opage_store.sv
`timescale 1ns/1ps
module opage_store
  import opage_pkg::*;
#(
  parameter int STACK_N = opage_pkg::STACK_N,
  localparam int DEPTH_W = $clog2(STACK_N + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  op_e                       op,
  input  entry_t                    push_entry,
  input  entry_t [STACK_N-1:0]      load_entries,
  input  logic [DEPTH_W-1:0]        load_depth,
  output entry_t [STACK_N-1:0]      entries,
  output logic [DEPTH_W-1:0]        depth,
  output logic                      overflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      depth    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= (op == OP_FULL);
      case (op)
        OP_LOAD:           depth <= load_depth;
        OP_CLEAR:          depth <= '0;
        OP_PUSH:           depth <= depth + 1'b1;
        OP_POP, OP_EXPIRE: depth <= depth - 1'b1;
        default:           depth <= depth;
      endcase
    end
  end

  for (genvar i = 0; i < STACK_N; i++) begin : g_ent
    entry_t q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        case (op)
          OP_LOAD:  q <= (DEPTH_W'(i) < load_depth) ? load_entries[i] : '0;
          OP_CLEAR: q <= '0;
          OP_PUSH:  if (depth == DEPTH_W'(i)) q <= push_entry;
          OP_POP, OP_EXPIRE: if (depth == DEPTH_W'(i + 1)) q <= '0;
          OP_DEC:   if (depth == DEPTH_W'(i + 1)) q.len <= q.len - 1'b1;
          default:  q <= q;
        endcase
      end
    end
    assign entries[i] = q;

    // R8: slots at or above the depth always hold zero
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (depth <= DEPTH_W'(i)) |-> (q == '0));
  end

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH_W'(STACK_N));
endmodule

// File: rtl/opage_view.sv
`timescale 1ns/1ps
module opage_view
  import opage_pkg::*;
#(
  parameter int STACK_N = opage_pkg::STACK_N,
  localparam int DEPTH_W = $clog2(STACK_N + 1),
  localparam int CSR_W   = STACK_N * ENTRY_W + DEPTH_W
) (
  input  entry_t [STACK_N-1:0] entries,
  input  logic [DEPTH_W-1:0]   depth,
  output entry_t               top_entry,
  output logic [PAGE_W-1:0]    active_page,
  output logic                 default_mode,
  output logic [CSR_W-1:0]     csr_word
);
  always_comb begin
    top_entry = '0;
    for (int k = 0; k < STACK_N; k++) begin
      if (depth == DEPTH_W'(k + 1)) top_entry = entries[k];
    end
  end

  assign active_page  = top_entry.page;
  assign default_mode = (depth == '0);

  for (genvar i = 0; i < STACK_N; i++) begin : g_pack
    assign csr_word[i*ENTRY_W +: ENTRY_W] = entries[i];
  end
  assign csr_word[CSR_W-1 -: DEPTH_W] = depth;
endmodule

// File: rtl/opage_esc_stack.sv
`timescale 1ns/1ps
module opage_esc_stack
  import opage_pkg::*;
#(
  parameter int STACK_N = opage_pkg::STACK_N,
  localparam int DEPTH_W = $clog2(STACK_N + 1),
  localparam int CSR_W   = STACK_N * ENTRY_W + DEPTH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [PAGE_W-1:0] push_page,
  input  logic [LEN_W-1:0]  push_len,
  input  logic              pop_one,
  input  logic              go_default,
  input  logic              retire,
  input  logic              branch_taken,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [PAGE_W-1:0] active_page,
  output logic              default_mode,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              overflow
);
  op_e                  op;
  entry_t [STACK_N-1:0] entries;
  entry_t [STACK_N-1:0] load_entries;
  entry_t               top_entry;
  entry_t               push_entry;
  logic [DEPTH_W-1:0]   depth;
  logic [DEPTH_W-1:0]   raw_depth;
  logic [DEPTH_W-1:0]   load_depth;

  assign push_entry   = '{page: push_page, len: push_len};
  assign load_entries = csr_wdata[STACK_N*ENTRY_W-1:0];
  assign raw_depth    = csr_wdata[CSR_W-1 -: DEPTH_W];
  assign load_depth   = (raw_depth > DEPTH_W'(STACK_N)) ? DEPTH_W'(STACK_N) : raw_depth;

  opage_cmd #(.STACK_N(STACK_N)) u_cmd (
    .csr_we(csr_we), .branch_taken(branch_taken), .go_default(go_default),
    .pop_one(pop_one), .push_valid(push_valid), .push_len(push_len),
    .retire(retire), .depth(depth), .top_len(top_entry.len), .op(op)
  );

  opage_store #(.STACK_N(STACK_N)) u_store (
    .clk(clk), .rst(rst), .op(op), .push_entry(push_entry),
    .load_entries(load_entries), .load_depth(load_depth),
    .entries(entries), .depth(depth), .overflow(overflow)
  );

  opage_view #(.STACK_N(STACK_N)) u_view (
    .entries(entries), .depth(depth), .top_entry(top_entry),
    .active_page(active_page), .default_mode(default_mode), .csr_word(csr_rdata)
  );

  logic quiet_hi;
  assign quiet_hi = !csr_we && !branch_taken && !go_default;

  p_branch_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (branch_taken && !csr_we) |=> (default_mode && csr_rdata == '0));

  p_default_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (go_default && !csr_we) |=> (default_mode && csr_rdata == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (quiet_hi && !pop_one && push_valid && push_len != '0 && depth == DEPTH_W'(STACK_N))
      |=> (overflow && $stable(csr_rdata)));

  p_push_grow_r2: assert property (@(posedge clk) disable iff (rst)
    (quiet_hi && !pop_one && push_valid && push_len != '0 && depth < DEPTH_W'(STACK_N))
      |=> (depth == $past(depth) + 1'b1 && active_page == $past(push_page)));

  p_perm_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (quiet_hi && !pop_one && !push_valid && retire && !default_mode && top_entry.len == '1)
      |=> $stable(csr_rdata));

  p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (quiet_hi && pop_one && default_mode) |=> (default_mode && !overflow));
endmodule

// File: tb/sim_opage_esc_stack.sv
`timescale 1ns/1ps
module sim_opage_esc_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 0, pop_one = 0, go_default = 0, retire = 0, branch_taken = 0, csr_we = 0;
  logic [2:0]  push_page = '0;
  logic [3:0]  push_len = '0;
  logic [30:0] csr_wdata = '0;
  logic [2:0]  active_page;
  logic        default_mode;
  logic [30:0] csr_rdata;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [2:0] mp [4];
  logic [3:0] ml [4];
  int         md;
  bit         movf;

  always #2.5 clk = ~clk;

  opage_esc_stack u0 (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_page(push_page),
    .push_len(push_len), .pop_one(pop_one), .go_default(go_default),
    .retire(retire), .branch_taken(branch_taken), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .active_page(active_page), .default_mode(default_mode),
    .csr_rdata(csr_rdata), .overflow(overflow)
  );

  function automatic logic [30:0] packed_model();
    logic [30:0] w = '0;
    for (int i = 0; i < 4; i++) w[i*7 +: 7] = {mp[i], ml[i]};
    w[30:28] = 3'(md);
    return w;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin mp[i] = '0; ml[i] = '0; end
    md = 0;
  endtask

  // Applies the requirement rules to the inputs present at the last edge.
  task automatic model_step(output string tag);
    int nact;
    movf = 0;
    nact = int'(pop_one) + int'(push_valid) + int'(retire);
    tag = "R11";
    if (csr_we) begin
      md = int'(csr_wdata[30:28]);
      if (md > 4) md = 4;
      for (int i = 0; i < 4; i++) begin
        if (i < md) begin mp[i] = csr_wdata[i*7+4 +: 3]; ml[i] = csr_wdata[i*7 +: 4]; end
        else begin mp[i] = '0; ml[i] = '0; end
      end
      tag = "R9";
    end else if (branch_taken || go_default) begin
      model_clear();
      tag = branch_taken ? "R6" : "R7";
    end else begin
      if (pop_one) begin
        if (md > 0) begin md--; mp[md] = '0; ml[md] = '0; end
        tag = "R8";
      end else if (push_valid) begin
        if (push_len == 4'd0) tag = "R3";
        else if (md == 4) begin movf = 1; tag = "R3"; end
        else begin mp[md] = push_page; ml[md] = push_len; md++; tag = "R2"; end
      end else if (retire && md > 0) begin
        if (ml[md-1] == 4'd15) tag = "R5";
        else if (ml[md-1] <= 4'd1) begin md--; mp[md] = '0; ml[md] = '0; tag = "R4"; end
        else begin ml[md-1] = ml[md-1] - 4'd1; tag = "R4"; end
      end
      if (nact > 1) tag = "R10";
    end
  endtask

  task automatic check_all(input string tag);
    logic [30:0] exp_w = packed_model();
    logic [2:0]  exp_p = (md > 0) ? mp[md-1] : 3'd0;
    checks++;
    if (csr_rdata !== exp_w) begin
      fails++;
      $display("FAIL %s csr_rdata actual %h expected %h", tag, csr_rdata, exp_w);
    end
    checks++;
    if (overflow !== movf) begin
      fails++;
      $display("FAIL %s overflow actual %0b expected %0b", tag, overflow, movf);
    end
    checks++;
    if (active_page !== exp_p || default_mode !== (md == 0)) begin
      fails++;
      $display("FAIL R11 active_page/default_mode actual %0d/%0b expected %0d/%0b",
               active_page, default_mode, exp_p, (md == 0));
    end
  endtask

  task automatic cyc(input bit pu, input logic [2:0] pg, input logic [3:0] ln,
                     input bit po, input bit df, input bit rt, input bit br,
                     input bit we, input logic [30:0] wd);
    string tag;
    push_valid = pu; push_page = pg; push_len = ln; pop_one = po;
    go_default = df; retire = rt; branch_taken = br; csr_we = we; csr_wdata = wd;
    @(negedge clk);
    model_step(tag);
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    model_clear();
    movf = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R2 then R4 countdown and expiry
    cyc(1, 3'd5, 4'd3, 0, 0, 0, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, '0);
    // R5 permanent entry
    cyc(1, 3'd2, 4'd15, 0, 0, 0, 0, 0, '0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 1, 0, 0, '0);
    // fill and overflow (R3)
    cyc(1, 3'd1, 4'd9, 0, 0, 0, 0, 0, '0);
    cyc(1, 3'd7, 4'd4, 0, 0, 0, 0, 0, '0);
    cyc(1, 3'd6, 4'd2, 0, 0, 0, 0, 0, '0);
    cyc(1, 3'd3, 4'd5, 0, 0, 0, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, '0);
    // R8 pop, R3 zero-length push ignored
    cyc(0, 0, 0, 1, 0, 0, 0, 0, '0);
    cyc(1, 3'd4, 4'd0, 0, 0, 0, 0, 0, '0);
    // R10 combinations
    cyc(1, 3'd4, 4'd6, 0, 0, 1, 0, 0, '0);
    cyc(1, 3'd1, 4'd6, 1, 0, 1, 0, 0, '0);
    // R6 branch with retire, R7 default
    cyc(0, 0, 0, 0, 0, 1, 1, 0, '0);
    cyc(1, 3'd2, 4'd8, 0, 0, 0, 0, 0, '0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, '0);
    // R8 pop when empty
    cyc(0, 0, 0, 1, 0, 0, 0, 0, '0);
    // R9 loads: junk above depth, clamp, priority over branch
    cyc(0, 0, 0, 0, 0, 0, 0, 1, {3'd2, 28'hFFF_FFFF});
    cyc(0, 0, 0, 0, 0, 0, 0, 1, {3'd7, 28'h9ABC_DEF});
    cyc(1, 3'd3, 4'd3, 1, 1, 1, 1, 1, {3'd1, 28'h000_0051});
    cyc(0, 0, 0, 0, 0, 1, 0, 0, '0);

    for (int n = 0; n < 6000; n++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r < 35, 3'($urandom), 4'($urandom),
          ($urandom_range(0, 99) < 8), ($urandom_range(0, 99) < 2),
          ($urandom_range(0, 99) < 65), ($urandom_range(0, 99) < 3),
          ($urandom_range(0, 99) < 2), 31'($urandom));
    end

    cyc(0, 0, 0, 0, 0, 0, 0, 0, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule